// File: doc/BRIEF.md
# Compare Match Timer Channel

This block is a register-mapped interval timer with a parameterized number of channels. Each channel owns an up-counter, a compare register and a control/status register. A start register shared by every channel carries one run bit per channel. While a channel runs, a selectable prescaler feeds count enables to its counter. When a count enable arrives and the counter already equals the compare value, the counter returns to zero and a sticky match flag is raised. The counting period is therefore (compare + 1) prescaled ticks. The flag drives the channel's interrupt line while the interrupt-enable bit is set, and software acknowledges the event by writing the control word back with the flag bit at 0.

The block is built in one of two variants, picked by a parameter. The narrow variant has a 16-bit counter and the flag at bit 7. The wide variant has a 32-bit counter, the flag at bit 15 and an extra wrap flag at bit 14. Software sees a word-addressed bus with single-cycle writes and reads whose data is registered.

Top module: `cmt_timer`

## Requirements
- R1: After reset every counter reads 0, every compare register reads all ones (0xFFFF narrow, 0xFFFFFFFF wide), every control word and the start register read 0, and no interrupt is asserted.
- R2: Word address 0 is the start register. Channel c uses word 4*(c+1) for control, 4*(c+1)+1 for counter and 4*(c+1)+2 for compare. Read data appears on `rdata` one cycle after the read strobe.
- R3: Bit c of the start register lets channel c count. While that bit is 0 the channel's counter holds, and no channel's bit affects another channel.
- R4: The prescale code is control bits [1:0] in the narrow variant, giving 8, 32, 128 or 512 clocks per tick. It is bits [2:0] in the wide variant, where code 0 gives 1 clock per tick and code k>0 gives 2^(k-1). The prescaler restarts when the run bit is set, so the first increment lands one full divide period after the write that set it.
- R5: On a tick with the counter equal to the compare value, the counter goes to 0 and the match flag is set; otherwise a tick adds one. The period is (compare+1) ticks, and a compare of 0 keeps the counter at 0.
- R6: The match flag is control bit 7 (narrow) or bit 15 (wide). A control write with that bit at 0 clears it, and a write with that bit at 1 leaves it unchanged. A match in the same cycle wins over the clear.
- R7: The interrupt of a channel is high exactly while its match flag and its interrupt-enable bit are both 1. The enable bit is control bit 6 (narrow) or bit 5 (wide), so writing control 0 silences the channel.
- R8: A bus write to a counter takes effect in place of a tick in the same cycle.
- R9: In the wide variant, control bit 14 is set when the counter rolls from all ones to 0 without a match. A control write with bit 14 at 0 clears it. The remaining non-flag control bits are stored and read back.
- R10: Control value 0x43 on a narrow channel gives an enabled periodic interrupt at clock/512. Control value 0x01A4 on a wide channel gives clock/8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | N_CH | One interrupt per channel |

## Verification
The counting function is tried with runs whose prescale code, compare value and waiting time are all drawn at random. The bench predicts the counter value and the flag from the number of clocks since the start write. A wrong divisor or an off-by-one in the first tick shows up as a counter value that does not match. A period of compare instead of compare+1 shows up as a flag set early. Directed runs cover:
- the two fixed control words;
- a zero compare value;
- a counter preset just below all ones, which separates the wrap flag from the match flag;
- a counter write racing a tick;
- the acknowledge writes, which tell a flag that is held by a 1 apart from one cleared by a 0.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;
  localparam int BUS_W = 32;
  localparam int PRE_W = 9;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_CMP  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Terminal value of the prescale counter (divisor - 1) for a code
  function automatic logic [PRE_W-1:0] div_last(input bit wide, input logic [2:0] code);
    int unsigned d;
    if (wide) d = (code == 3'd0) ? 1 : (1 << (code - 3'd1));
    else      d = 8 << (2 * code[1:0]);
    return PRE_W'(d - 1);
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
`timescale 1ns/1ps
module cmt_prescaler import cmt_pkg::*; #(
  parameter bit WIDE = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] last;

  assign last   = div_last(WIDE, sel_i);
  assign tick_o = run_i && (pre_q >= last);

  always_ff @(posedge clk) begin
    if (rst || !run_i)      pre_q <= '0;
    else if (pre_q >= last) pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end

  // R4
  pre_restart_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run_i) |-> (pre_q == '0));
endmodule

// File: rtl/cmt_channel.sv
`timescale 1ns/1ps
module cmt_channel import cmt_pkg::*; #(
  parameter bit WIDE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             ctrl_we,
  input  logic             cnt_we,
  input  logic             cmp_we,
  input  logic [BUS_W-1:0] wdata,
  output logic [15:0]      ctrl_o,
  output logic [BUS_W-1:0] cnt_o,
  output logic [BUS_W-1:0] cmp_o,
  output logic             irq_o
);
  localparam int CNT_W    = WIDE ? 32 : 16;
  localparam int FLAG_BIT = WIDE ? 15 : 7;
  localparam int WRAP_BIT = 14;
  localparam int IE_BIT   = WIDE ? 5 : 6;
  localparam logic [15:0] CFG_MASK = WIDE ? 16'h3FFF : 16'h007F;

  logic [15:0]      cfg_q;
  logic             flag_q, wrap_q;
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic [2:0]       cks;
  logic             tick, match, roll;
  logic             unused_w;

  assign unused_w = ^wdata;
  assign cks      = WIDE ? cfg_q[2:0] : {1'b0, cfg_q[1:0]};

  cmt_prescaler #(.WIDE(WIDE)) u_pre (
    .clk(clk), .rst(rst), .run_i(run_i), .sel_i(cks), .tick_o(tick)
  );

  assign match = tick && (cnt_q == cmp_q);
  assign roll  = tick && !match && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
      wrap_q <= 1'b0;
      cnt_q  <= '0;
      cmp_q  <= '1;
    end else begin
      if (ctrl_we) cfg_q <= wdata[15:0] & CFG_MASK;
      if (match)                              flag_q <= 1'b1;
      else if (ctrl_we && !wdata[FLAG_BIT])   flag_q <= 1'b0;
      if (WIDE && roll)                       wrap_q <= 1'b1;
      else if (ctrl_we && !wdata[WRAP_BIT])   wrap_q <= 1'b0;
      if (cnt_we)     cnt_q <= wdata[CNT_W-1:0];
      else if (match) cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_q + 1'b1;
      if (cmp_we) cmp_q <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    ctrl_o = cfg_q;
    ctrl_o[FLAG_BIT] = flag_q;
    if (WIDE) ctrl_o[WRAP_BIT] = wrap_q;
  end

  assign cnt_o = BUS_W'(cnt_q);
  assign cmp_o = BUS_W'(cmp_q);
  assign irq_o = flag_q & cfg_q[IE_BIT];

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !cnt_we) |=> $stable(cnt_q));
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !ctrl_we) |=> flag_q);
  // R5
  match_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && (cnt_q == cmp_q) && !cnt_we) |=> ((cnt_q == '0) && flag_q));
  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_we |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0)));
endmodule

// File: rtl/cmt_timer.sv
`timescale 1ns/1ps
module cmt_timer import cmt_pkg::*; #(
  parameter int N_CH   = 2,
  parameter bit WIDE   = 1'b0,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic [N_CH-1:0]   irq
);
  localparam int BLK_W = ADDR_W - 2;

  logic [N_CH-1:0]  run_q;
  logic [BLK_W-1:0] blk;
  reg_sel_e         sel;
  logic [15:0]      ctrl_rd [N_CH];
  logic [BUS_W-1:0] cnt_rd  [N_CH];
  logic [BUS_W-1:0] cmp_rd  [N_CH];
  logic [BUS_W-1:0] rd_next;

  assign blk = addr[ADDR_W-1:2];
  assign sel = reg_sel_e'(addr[1:0]);

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (wr_en && blk == '0 && sel == SEL_CTRL) run_q <= wdata[N_CH-1:0];
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic hit;
    assign hit = (blk == BLK_W'(c + 1));
    cmt_channel #(.WIDE(WIDE)) u_ch (
      .clk(clk), .rst(rst), .run_i(run_q[c]),
      .ctrl_we(wr_en && hit && sel == SEL_CTRL),
      .cnt_we (wr_en && hit && sel == SEL_CNT),
      .cmp_we (wr_en && hit && sel == SEL_CMP),
      .wdata(wdata), .ctrl_o(ctrl_rd[c]), .cnt_o(cnt_rd[c]),
      .cmp_o(cmp_rd[c]), .irq_o(irq[c])
    );
  end

  always_comb begin
    rd_next = '0;
    if (blk == '0 && sel == SEL_CTRL) rd_next = BUS_W'(run_q);
    for (int c = 0; c < N_CH; c++) begin
      if (blk == BLK_W'(c + 1)) begin
        case (sel)
          SEL_CTRL: rd_next = BUS_W'(ctrl_rd[c]);
          SEL_CNT:  rd_next = cnt_rd[c];
          SEL_CMP:  rd_next = cmp_rd[c];
          default:  rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end
endmodule

// File: tb/tb_cmt_timer.sv
`timescale 1ns/1ps
module tb_cmt_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_s = 1'b0, rd_s = 1'b0, wr_w = 1'b0, rd_w = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_s, rdata_w;
  logic [1:0]  irq_s, irq_w;
  int cyc = 0;
  int last_edge = 0;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmt_timer #(.N_CH(2), .WIDE(1'b0), .ADDR_W(4)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_s), .rd_en(rd_s), .addr(addr),
    .wdata(wdata), .rdata(rdata_s), .irq(irq_s));
  cmt_timer #(.N_CH(2), .WIDE(1'b1), .ADDR_W(4)) dut_w (
    .clk(clk), .rst(rst), .wr_en(wr_w), .rd_en(rd_w), .addr(addr),
    .wdata(wdata), .rdata(rdata_w), .irq(irq_w));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit w, input int a, input logic [31:0] d);
    addr = 4'(a); wdata = d;
    if (w) wr_w = 1'b1; else wr_s = 1'b1;
    @(posedge clk); #1;
    wr_s = 1'b0; wr_w = 1'b0; last_edge = cyc;
  endtask

  task automatic rd(input bit w, input int a, output logic [31:0] d);
    addr = 4'(a);
    if (w) rd_w = 1'b1; else rd_s = 1'b1;
    @(posedge clk); #1;
    rd_s = 1'b0; rd_w = 1'b0; last_edge = cyc;
    d = w ? rdata_w : rdata_s;
  endtask

  function automatic int divisor(input bit w, input logic [15:0] cv);
    if (w) return (cv[2:0] == 3'd0) ? 1 : (1 << (cv[2:0] - 3'd1));
    return 8 << (2 * cv[1:0]);
  endfunction

  // Start one channel from zero and predict count, flag and interrupt
  task automatic trial(input bit w, input int ch, input logic [15:0] cv,
                       input int cmpv, input int n, input string req);
    int s, r, t, dv, base;
    logic [31:0] d, ectrl;
    bit ie, fl;
    base = 4 * (ch + 1);
    dv = divisor(w, cv);
    ie = w ? cv[5] : cv[6];
    wr(w, 0, 0);
    wr(w, base + 1, 0);
    wr(w, base + 2, 32'(cmpv));
    wr(w, base, 32'(cv));
    wr(w, 0, 32'(1 << ch));
    s = last_edge;
    repeat (n) @(posedge clk);
    #1;
    rd(w, base + 1, d); r = last_edge;
    t = (r - 1 - s) / dv;
    chk({req, " R4 R5 count"}, d, 32'(t % (cmpv + 1)));
    rd(w, base, d); r = last_edge;
    t = (r - 1 - s) / dv;
    fl = (t >= cmpv + 1);
    ectrl = 32'(cv) | (fl ? (32'd1 << (w ? 15 : 7)) : 32'd0);
    chk({req, " R6 flag"}, d, ectrl);
    t = (r - s) / dv;
    chk({req, " R7 irq"}, 32'(w ? irq_w[ch] : irq_s[ch]), 32'(ie && (t >= cmpv + 1)));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog R1..: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, a0;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1; rst = 1'b0;
    @(posedge clk); #1;

    // R1 reset state, R2 map
    rd(0, 5, d); chk("R1 narrow cnt", d, 0);
    rd(0, 6, d); chk("R1 narrow cmp", d, 32'h0000FFFF);
    rd(1, 6, d); chk("R1 wide cmp", d, 32'hFFFFFFFF);
    rd(0, 4, d); chk("R1 ctrl", d, 0);
    rd(1, 0, d); chk("R1 R2 start", d, 0);
    chk("R1 irq", {28'd0, irq_s, irq_w}, 0);

    // R10 narrow 0x43; R3 neighbour untouched
    wr(0, 9, 7);
    trial(0, 0, 16'h0043, 3, 2100, "R10 narrow");
    rd(0, 9, d); chk("R3 other channel", d, 7);
    wr(0, 0, 0);
    rd(0, 5, a0);
    repeat (600) @(posedge clk);
    #1;
    rd(0, 5, d); chk("R3 hold when stopped", d, a0);

    // R6 / R7 acknowledge semantics (flag set by the trial above)
    wr(0, 4, 32'h00C3);
    rd(0, 4, d); chk("R6 write 1 keeps flag", d, 32'h00C3);
    chk("R7 irq with flag and enable", 32'(irq_s[0]), 1);
    wr(0, 4, 32'h0080);
    rd(0, 4, d); chk("R7 enable off keeps flag", d, 32'h0080);
    chk("R7 irq masked", 32'(irq_s[0]), 0);
    wr(0, 4, 32'h0043);
    rd(0, 4, d); chk("R6 write 0 clears flag", d, 32'h0043);
    chk("R7 irq after clear", 32'(irq_s[0]), 0);

    // R10 wide 0x01A4
    trial(1, 0, 16'h01A4, 9, 150, "R10 wide");
    // R5 compare of zero
    trial(1, 1, 16'h0020, 0, 13, "R5 zero compare");

    // R8 counter write beats tick
    wr(1, 0, 0);
    wr(1, 10, 1000);
    wr(1, 8, 32'h0020);
    wr(1, 0, 2);
    repeat (5) @(posedge clk);
    #1;
    wr(1, 9, 100);
    rd(1, 9, d); chk("R8 write wins", d, 100);
    rd(1, 9, d); chk("R8 counting resumes", d, 101);
    rd(1, 5, a0);
    repeat (40) @(posedge clk);
    #1;
    rd(1, 5, d); chk("R3 wide idle channel", d, a0);

    // R9 wrap flag
    wr(1, 0, 0);
    wr(1, 6, 5);
    wr(1, 5, 32'hFFFFFFFE);
    wr(1, 4, 32'h0020);
    wr(1, 0, 1);
    repeat (20) @(posedge clk);
    #1;
    rd(1, 4, d); chk("R9 wrap and match", d, 32'h0000C020);
    wr(1, 4, 32'h8020);
    rd(1, 4, d); chk("R9 wrap cleared", d, 32'h00008020);
    wr(1, 0, 0);
    wr(1, 4, 32'h0020);
    rd(1, 4, d); chk("R6 wide clear", d, 32'h00000020);

    // Random runs: prescale, compare, wait
    for (int i = 0; i < 14; i++) begin
      logic [15:0] cv;
      int cmpv, dv;
      cv = 16'(($urandom & 32'h3C) | (($urandom & 1) << 6) | ($urandom & 3));
      cmpv = $urandom_range(6, 1);
      dv = divisor(0, cv);
      trial(0, i % 2, cv, cmpv, $urandom_range(dv * (cmpv + 3), 1), "narrow random");
    end
    for (int i = 0; i < 14; i++) begin
      logic [15:0] cv;
      int cmpv, dv;
      cv = 16'(($urandom & 32'h3F00) | (($urandom & 1) << 5) | ($urandom & 7));
      cmpv = $urandom_range(30, 0);
      dv = divisor(1, cv);
      trial(1, i % 2, cv, cmpv, $urandom_range(dv * (cmpv + 3), 1), "wide random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule